// File: doc/BRIEF.md
# Reset-Time Strap Configuration Sampler

This block reads a set of configuration straps exactly once after reset. It turns them into the configuration that a USB hub controller runs with. Each strap arrives already resolved into two signals: a valid flag, which is low when the pin was found floating, and a logic value. The block combines these with a master enable strap, with group and per-bit validity rules, and with a set of default inputs. From them it produces a per-port enable mask, a removable-device mask, per-port charging enables, the power-switch polarity, the power-control mode, a vendor-ID select and a 7-bit I2C slave address.

Capture happens on the first clock edge after reset is released. On the next cycle the block raises a done flag and a release flag, which hand the shared pins back to general-purpose use. After that the configuration is frozen until the next reset, so later activity on the pins has no effect. A factory port mask always constrains the result. Straps can narrow the set of enabled ports but can never widen it.

Top module: `strap_cfg_sampler`

## Requirements
- R1: Straps are captured on the first rising clock edge where `rst` is low. From that edge onward, `sample_done` and `gpio_release` are 1 and every configuration output holds its value until `rst` is asserted again, whatever the strap inputs do.
- R2: While `rst` is high, `sample_done` and `gpio_release` are 0. The configuration outputs take these values:
  - `port_en` is `dflt_port_en & factory_port_mask`.
  - `port_removable`, `chg_en`, `pwr_pol`, `pwr_gang` and `vid_sel` equal their default inputs.
  - `i2c_addr` is 0x60.
- R3: Straps are used only if `strap_en_vld` and `strap_en_val` are both 1. Otherwise every output captures its default, with the address at 0x60.
- R4: The single-bit straps are `pol`, `gang`, `devid` and each `chg` bit. Each one is used only when its own valid bit is 1; otherwise the matching default is kept.
- R5: `pdis`, `nrem` and `vid` are groups. If any valid bit of a group is 0, the whole group is ignored and its default is captured.
- R6: The port-disable code `pdis_val[1:0]` (bit 1 is the MSB) is c. The strap port mask then enables ports 1 to 4−c, where port 1 is bit 0 of `port_en`. So 0 enables all four ports and 3 enables port 1 only.
- R7: The non-removable code `nrem_val` uses the same mapping to set `port_removable`, where 1 means removable. Ports outside that set read 0.
- R8: The captured `port_en` is the strap mask (or the default mask) ANDed with `factory_port_mask`.
- R9: The effective polarity is `pol_val` if that strap is used, else `dflt_pol`; `pwr_pol` outputs it. A used `chg` strap bit gives `chg_en = chg_val` when the polarity is 1, and `~chg_val` when it is 0.
- R10: When `i2c_slave_mode` is 1 and the ID strap is used, `i2c_addr` is 0x60 for value 0 and 0x58 for value 1. In every other case it is 0x60.
- R11: A used vendor-ID group is copied bit for bit to `vid_sel[2:0]`, and a used gang strap is copied to `pwr_gang`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i2c_slave_mode | input | 1 | 1 when the device runs as an I2C slave |
| factory_port_mask | input | 4 | Ports the factory allows |
| dflt_port_en | input | 4 | Default port enable mask |
| dflt_removable | input | 4 | Default removable mask |
| dflt_chg_en | input | 4 | Default charging enables |
| dflt_pol | input | 1 | Default power-switch polarity |
| dflt_gang | input | 1 | Default power-control mode (1 = ganged) |
| dflt_vid | input | 3 | Default vendor-ID select |
| strap_en_vld | input | 1 | Master enable strap not floating |
| strap_en_val | input | 1 | Master enable strap level |
| pol_vld | input | 1 | Polarity strap valid |
| pol_val | input | 1 | Polarity strap value |
| chg_vld | input | 4 | Charging strap valid, per port |
| chg_val | input | 4 | Charging strap raw level, per port |
| pdis_vld | input | 2 | Port-disable code valid bits |
| pdis_val | input | 2 | Port-disable code |
| nrem_vld | input | 2 | Non-removable code valid bits |
| nrem_val | input | 2 | Non-removable code |
| gang_vld | input | 1 | Power-mode strap valid |
| gang_val | input | 1 | Power-mode strap value |
| vid_vld | input | 3 | Vendor-ID strap valid bits |
| vid_val | input | 3 | Vendor-ID strap values |
| devid_vld | input | 1 | I2C ID strap valid |
| devid_val | input | 1 | I2C ID strap value |
| port_en | output | 4 | Captured port enable mask |
| port_removable | output | 4 | Captured removable mask |
| chg_en | output | 4 | Captured charging enables |
| pwr_pol | output | 1 | Effective power-switch polarity |
| pwr_gang | output | 1 | Power-control mode |
| vid_sel | output | 3 | Vendor-ID select |
| i2c_addr | output | 7 | I2C slave address |
| sample_done | output | 1 | Capture complete |
| gpio_release | output | 1 | Pins returned to normal use |

## Verification
The bench targets group straps with a single floating bit. A design that checked validity per bit instead would mix strap and default bits in `port_en`, `port_removable` or `vid_sel`. It also flips the polarity strap and makes it invalid, so that charging bits read against the wrong polarity, or against the strap value when the default should apply, come out inverted. It changes the straps after capture, which exposes a design that keeps sampling. It also forces a low or floating master enable, a disallowed factory port, and the ID strap outside slave mode, where a wrong design would let straps through, enable a forbidden port, or move the address to 0x58.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int I2C_ADDR_W = 7;
  typedef enum logic {
    POL_ACT_LOW  = 1'b0,
    POL_ACT_HIGH = 1'b1
  } sw_pol_e;
endpackage

// File: rtl/strap_group_gate.sv
// Qualifies a group of straps: the group is taken only when the master
// enable is on and every member is driven.
module strap_group_gate #(
  parameter int W = 2
) (
  input  logic         master_ok,
  input  logic [W-1:0] vld,
  input  logic [W-1:0] val,
  input  logic [W-1:0] dflt,
  output logic [W-1:0] sel,
  output logic         used
);
  always_comb begin
    used = master_ok && (&vld);
    sel  = used ? val : dflt;
  end
endmodule

// File: rtl/strap_port_decode.sv
// Turns a count-style code into a mask of the lowest NUM_PORTS-code ports.
module strap_port_decode #(
  parameter int NUM_PORTS = 4,
  parameter int CODE_W    = $clog2(NUM_PORTS)
) (
  input  logic [CODE_W-1:0]    code,
  output logic [NUM_PORTS-1:0] mask
);
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_bit
    assign mask[i] = (i + int'(code)) < NUM_PORTS;
  end
endmodule

// File: rtl/strap_chg_decode.sv
// Per-port charging enable with polarity chosen by another strap.
module strap_chg_decode #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 master_ok,
  input  logic                 pol,
  input  logic [NUM_PORTS-1:0] vld,
  input  logic [NUM_PORTS-1:0] val,
  input  logic [NUM_PORTS-1:0] dflt,
  output logic [NUM_PORTS-1:0] en
);
  import strap_cfg_pkg::*;
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic level;
    assign level = (sw_pol_e'(pol) == POL_ACT_HIGH) ? val[i] : ~val[i];
    assign en[i] = (master_ok && vld[i]) ? level : dflt[i];
  end
endmodule

// File: rtl/strap_cfg_sampler.sv
module strap_cfg_sampler
  import strap_cfg_pkg::*;
#(
  parameter int                  NUM_PORTS = 4,
  parameter int                  CODE_W    = $clog2(NUM_PORTS),
  parameter int                  VID_W     = 3,
  parameter logic [I2C_ADDR_W-1:0] ADDR_ID0 = 7'h60,
  parameter logic [I2C_ADDR_W-1:0] ADDR_ID1 = 7'h58
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  i2c_slave_mode,
  input  logic [NUM_PORTS-1:0]  factory_port_mask,
  input  logic [NUM_PORTS-1:0]  dflt_port_en,
  input  logic [NUM_PORTS-1:0]  dflt_removable,
  input  logic [NUM_PORTS-1:0]  dflt_chg_en,
  input  logic                  dflt_pol,
  input  logic                  dflt_gang,
  input  logic [VID_W-1:0]      dflt_vid,
  input  logic                  strap_en_vld,
  input  logic                  strap_en_val,
  input  logic                  pol_vld,
  input  logic                  pol_val,
  input  logic [NUM_PORTS-1:0]  chg_vld,
  input  logic [NUM_PORTS-1:0]  chg_val,
  input  logic [CODE_W-1:0]     pdis_vld,
  input  logic [CODE_W-1:0]     pdis_val,
  input  logic [CODE_W-1:0]     nrem_vld,
  input  logic [CODE_W-1:0]     nrem_val,
  input  logic                  gang_vld,
  input  logic                  gang_val,
  input  logic [VID_W-1:0]      vid_vld,
  input  logic [VID_W-1:0]      vid_val,
  input  logic                  devid_vld,
  input  logic                  devid_val,
  output logic [NUM_PORTS-1:0]  port_en,
  output logic [NUM_PORTS-1:0]  port_removable,
  output logic [NUM_PORTS-1:0]  chg_en,
  output logic                  pwr_pol,
  output logic                  pwr_gang,
  output logic [VID_W-1:0]      vid_sel,
  output logic [I2C_ADDR_W-1:0] i2c_addr,
  output logic                  sample_done,
  output logic                  gpio_release
);
  logic master_ok;
  assign master_ok = strap_en_vld && strap_en_val;

  // Single-bit straps, each under its own valid flag.
  logic eff_pol, eff_gang, id_used;
  assign eff_pol  = (master_ok && pol_vld)  ? pol_val  : dflt_pol;
  assign eff_gang = (master_ok && gang_vld) ? gang_val : dflt_gang;
  assign id_used  = master_ok && devid_vld && i2c_slave_mode;

  logic [I2C_ADDR_W-1:0] eff_addr;
  assign eff_addr = (id_used && devid_val) ? ADDR_ID1 : ADDR_ID0;

  // Port-disable group.
  logic [CODE_W-1:0]    pdis_code;
  logic                 pdis_used;
  logic [NUM_PORTS-1:0] pdis_mask;
  strap_group_gate #(.W(CODE_W)) u_pdis_gate (
    .master_ok(master_ok), .vld(pdis_vld), .val(pdis_val),
    .dflt('0), .sel(pdis_code), .used(pdis_used)
  );
  strap_port_decode #(.NUM_PORTS(NUM_PORTS), .CODE_W(CODE_W)) u_pdis_dec (
    .code(pdis_code), .mask(pdis_mask)
  );

  // Non-removable group.
  logic [CODE_W-1:0]    nrem_code;
  logic                 nrem_used;
  logic [NUM_PORTS-1:0] nrem_mask;
  strap_group_gate #(.W(CODE_W)) u_nrem_gate (
    .master_ok(master_ok), .vld(nrem_vld), .val(nrem_val),
    .dflt('0), .sel(nrem_code), .used(nrem_used)
  );
  strap_port_decode #(.NUM_PORTS(NUM_PORTS), .CODE_W(CODE_W)) u_nrem_dec (
    .code(nrem_code), .mask(nrem_mask)
  );

  // Vendor-ID group.
  logic [VID_W-1:0] eff_vid;
  logic             vid_used;
  strap_group_gate #(.W(VID_W)) u_vid_gate (
    .master_ok(master_ok), .vld(vid_vld), .val(vid_val),
    .dflt(dflt_vid), .sel(eff_vid), .used(vid_used)
  );

  // Charging enables read against the effective polarity.
  logic [NUM_PORTS-1:0] eff_chg;
  strap_chg_decode #(.NUM_PORTS(NUM_PORTS)) u_chg (
    .master_ok(master_ok), .pol(eff_pol), .vld(chg_vld), .val(chg_val),
    .dflt(dflt_chg_en), .en(eff_chg)
  );

  logic [NUM_PORTS-1:0] eff_port, eff_rem;
  assign eff_port = (pdis_used ? pdis_mask : dflt_port_en) & factory_port_mask;
  assign eff_rem  = nrem_used ? nrem_mask : dflt_removable;

  // Configuration registers: defaults in reset, one load, then frozen.
  always_ff @(posedge clk) begin
    if (rst) begin
      port_en        <= dflt_port_en & factory_port_mask;
      port_removable <= dflt_removable;
      chg_en         <= dflt_chg_en;
      pwr_pol        <= dflt_pol;
      pwr_gang       <= dflt_gang;
      vid_sel        <= dflt_vid;
      i2c_addr       <= ADDR_ID0;
      sample_done    <= 1'b0;
      gpio_release   <= 1'b0;
    end else if (!sample_done) begin
      port_en        <= eff_port;
      port_removable <= eff_rem;
      chg_en         <= eff_chg;
      pwr_pol        <= eff_pol;
      pwr_gang       <= eff_gang;
      vid_sel        <= eff_vid;
      i2c_addr       <= eff_addr;
      sample_done    <= 1'b1;
      gpio_release   <= 1'b1;
    end
  end
endmodule

// File: rtl/strap_cfg_sampler_chk.sv
module strap_cfg_sampler_chk #(
  parameter int NUM_PORTS = 4,
  parameter int VID_W     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 i2c_slave_mode,
  input logic [NUM_PORTS-1:0] factory_port_mask,
  input logic                 dflt_pol,
  input logic [VID_W-1:0]     dflt_vid,
  input logic                 strap_en_vld,
  input logic                 strap_en_val,
  input logic [NUM_PORTS-1:0] port_en,
  input logic [NUM_PORTS-1:0] chg_en,
  input logic [NUM_PORTS-1:0] port_removable,
  input logic                 pwr_pol,
  input logic [VID_W-1:0]     vid_sel,
  input logic [6:0]           i2c_addr,
  input logic                 sample_done,
  input logic                 gpio_release
);
  // R1
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sample_done |=> sample_done);
  // R1
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    sample_done |=> ($stable(port_en) && $stable(chg_en) && $stable(port_removable)
                     && $stable(i2c_addr) && $stable(vid_sel) && $stable(pwr_pol)));
  // R1
  release_match_chk: assert property (@(posedge clk) disable iff (rst)
    gpio_release == sample_done);
  // R2
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!sample_done && !gpio_release));
  // R8
  factory_limit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_done) |-> ((port_en & ~$past(factory_port_mask)) == '0));
  // R10
  addr_default_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sample_done) && !$past(i2c_slave_mode)) |-> (i2c_addr == 7'h60));
  // R3
  master_off_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sample_done) && !($past(strap_en_vld) && $past(strap_en_val)))
      |-> (pwr_pol == $past(dflt_pol) && vid_sel == $past(dflt_vid)));
endmodule

bind strap_cfg_sampler strap_cfg_sampler_chk #(
  .NUM_PORTS(NUM_PORTS), .VID_W(VID_W)
) u_chk (
  .clk(clk), .rst(rst), .i2c_slave_mode(i2c_slave_mode),
  .factory_port_mask(factory_port_mask), .dflt_pol(dflt_pol),
  .dflt_vid(dflt_vid), .strap_en_vld(strap_en_vld),
  .strap_en_val(strap_en_val), .port_en(port_en), .chg_en(chg_en),
  .port_removable(port_removable), .pwr_pol(pwr_pol), .vid_sel(vid_sel),
  .i2c_addr(i2c_addr), .sample_done(sample_done), .gpio_release(gpio_release)
);

// File: tb/strap_cfg_sampler_tb.sv
module strap_cfg_sampler_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       slave, m_vld, m_val, d_pol, d_gang, p_vld, p_val, g_vld, g_val, id_vld, id_val;
  logic [3:0] fac, d_port, d_rem, d_chg, c_vld, c_val;
  logic [1:0] pd_vld, pd_val, nr_vld, nr_val;
  logic [2:0] d_vid, v_vld, v_val;

  logic [3:0] port_en, port_removable, chg_en;
  logic       pwr_pol, pwr_gang, sample_done, gpio_release;
  logic [2:0] vid_sel;
  logic [6:0] i2c_addr;

  strap_cfg_sampler dut_i (
    .clk(clk), .rst(rst), .i2c_slave_mode(slave), .factory_port_mask(fac),
    .dflt_port_en(d_port), .dflt_removable(d_rem), .dflt_chg_en(d_chg),
    .dflt_pol(d_pol), .dflt_gang(d_gang), .dflt_vid(d_vid),
    .strap_en_vld(m_vld), .strap_en_val(m_val), .pol_vld(p_vld), .pol_val(p_val),
    .chg_vld(c_vld), .chg_val(c_val), .pdis_vld(pd_vld), .pdis_val(pd_val),
    .nrem_vld(nr_vld), .nrem_val(nr_val), .gang_vld(g_vld), .gang_val(g_val),
    .vid_vld(v_vld), .vid_val(v_val), .devid_vld(id_vld), .devid_val(id_val),
    .port_en(port_en), .port_removable(port_removable), .chg_en(chg_en),
    .pwr_pol(pwr_pol), .pwr_gang(pwr_gang), .vid_sel(vid_sel),
    .i2c_addr(i2c_addr), .sample_done(sample_done), .gpio_release(gpio_release)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] code_mask(logic [1:0] c);
    logic [3:0] m;
    for (int i = 0; i < 4; i++) m[i] = (i < 4 - int'(c));
    return m;
  endfunction

  function automatic logic master(); return m_vld & m_val; endfunction
  function automatic logic x_pol(); return (master() && p_vld) ? p_val : d_pol; endfunction
  function automatic logic [3:0] x_port();
    return ((master() && &pd_vld) ? code_mask(pd_val) : d_port) & fac;
  endfunction
  function automatic logic [3:0] x_rem();
    return (master() && &nr_vld) ? code_mask(nr_val) : d_rem;
  endfunction
  function automatic logic [3:0] x_chg();
    logic [3:0] r;
    for (int i = 0; i < 4; i++)
      r[i] = (master() && c_vld[i]) ? (x_pol() ? c_val[i] : ~c_val[i]) : d_chg[i];
    return r;
  endfunction
  function automatic logic x_gang(); return (master() && g_vld) ? g_val : d_gang; endfunction
  function automatic logic [2:0] x_vid(); return (master() && &v_vld) ? v_val : d_vid; endfunction
  function automatic logic [6:0] x_addr();
    return (master() && id_vld && slave && id_val) ? 7'h58 : 7'h60;
  endfunction

  task automatic randomize_all();
    fac = 4'($urandom); d_port = 4'($urandom); d_rem = 4'($urandom);
    d_chg = 4'($urandom); d_pol = 1'($urandom); d_gang = 1'($urandom);
    d_vid = 3'($urandom); slave = 1'($urandom);
    m_vld = ($urandom % 5) != 0; m_val = ($urandom % 5) != 0;
    p_vld = ($urandom % 4) != 0; p_val = 1'($urandom);
    g_vld = ($urandom % 4) != 0; g_val = 1'($urandom);
    id_vld = ($urandom % 4) != 0; id_val = 1'($urandom);
    c_val = 4'($urandom); pd_val = 2'($urandom); nr_val = 2'($urandom); v_val = 3'($urandom);
    for (int i = 0; i < 4; i++) c_vld[i] = ($urandom % 4) != 0;
    for (int i = 0; i < 2; i++) begin
      pd_vld[i] = ($urandom % 5) != 0; nr_vld[i] = ($urandom % 5) != 0;
    end
    for (int i = 0; i < 3; i++) v_vld[i] = ($urandom % 6) != 0;
  endtask

  // Expected values held from the capture, used after straps move.
  logic [3:0] h_port, h_rem, h_chg;
  logic       h_pol, h_gang;
  logic [2:0] h_vid;
  logic [6:0] h_addr;

  task automatic run_case(string tag);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R2 reset state
    check({tag, " R2 done"}, {sample_done, gpio_release}, 2'b00);
    check({tag, " R2 port_en"}, port_en, d_port & fac);
    check({tag, " R2 rem"}, port_removable, d_rem);
    check({tag, " R2 chg"}, chg_en, d_chg);
    check({tag, " R2 pol/gang/vid"}, {pwr_pol, pwr_gang, vid_sel}, {d_pol, d_gang, d_vid});
    check({tag, " R2 addr"}, i2c_addr, 7'h60);
    rst = 1'b0;
    h_port = x_port(); h_rem = x_rem(); h_chg = x_chg(); h_pol = x_pol();
    h_gang = x_gang(); h_vid = x_vid(); h_addr = x_addr();
    @(posedge clk);
    @(negedge clk);
    check({tag, " R1 done/release"}, {sample_done, gpio_release}, 2'b11);
    check({tag, " R6 R8 port_en"}, port_en, h_port);
    check({tag, " R7 removable"}, port_removable, h_rem);
    check({tag, " R9 chg_en"}, chg_en, h_chg);
    check({tag, " R9 pwr_pol"}, pwr_pol, h_pol);
    check({tag, " R11 gang"}, pwr_gang, h_gang);
    check({tag, " R11 vid"}, vid_sel, h_vid);
    check({tag, " R10 addr"}, i2c_addr, h_addr);
    // R1: straps move after capture; nothing follows them
    m_vld = 1'b1; m_val = 1'b1; p_vld = 1'b1; p_val = ~p_val; c_vld = 4'hF;
    c_val = ~c_val; pd_vld = 2'b11; pd_val = ~pd_val; nr_vld = 2'b11; nr_val = ~nr_val;
    v_vld = 3'b111; v_val = ~v_val; g_vld = 1'b1; g_val = ~g_val;
    id_vld = 1'b1; id_val = ~id_val; slave = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({tag, " R1 frozen cfg"},
          {port_en, port_removable, chg_en, pwr_pol, pwr_gang, vid_sel, i2c_addr},
          {h_port, h_rem, h_chg, h_pol, h_gang, h_vid, h_addr});
    check({tag, " R1 done held"}, {sample_done, gpio_release}, 2'b11);
  endtask

  task automatic all_good();
    m_vld = 1; m_val = 1; p_vld = 1; g_vld = 1; id_vld = 1;
    c_vld = 4'hF; pd_vld = 2'b11; nr_vld = 2'b11; v_vld = 3'b111;
  endtask

  initial begin
    void'($urandom(32'h51A7));
    randomize_all();
    @(negedge clk);
    // R3 master enable floating, then low
    randomize_all(); all_good(); m_vld = 0; run_case("R3 floating");
    randomize_all(); all_good(); m_val = 0; run_case("R3 low");
    // R4 single straps floating
    randomize_all(); all_good(); p_vld = 0; g_vld = 0; id_vld = 0; c_vld = 4'b0101;
    run_case("R4 singles");
    // R5 one bit of each group floating
    randomize_all(); all_good(); pd_vld = 2'b10; nr_vld = 2'b01; v_vld = 3'b011;
    run_case("R5 partial");
    // R6 R7 every code; R9 both polarities
    for (int c = 0; c < 4; c++) begin
      randomize_all(); all_good(); fac = 4'hF; pd_val = 2'(c); nr_val = 2'(3 - c);
      p_val = c[0]; run_case("R6 R7 R9 code");
    end
    // R8 factory removes a port the strap enables
    randomize_all(); all_good(); pd_val = 2'b00; fac = 4'b1010; run_case("R8 factory");
    // R10 slave mode off and on with ID 1
    randomize_all(); all_good(); id_val = 1; slave = 0; run_case("R10 master mode");
    randomize_all(); all_good(); id_val = 1; slave = 1; run_case("R10 slave id1");
    for (int k = 0; k < 40; k++) begin
      randomize_all(); run_case("random");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule